// File: doc/BRIEF.md
# Data EEPROM Write Controller

This block sits in front of a small on-chip data EEPROM array and exposes it to software through five registers selected by `reg_sel`: a control register, a low and a high address register, a data register and a key register. Software can read one 16-bit word at any time. It can also erase or program one word, or an aligned group of 16 words. A program or erase runs for a long, parameterised time. During that time the register bus stays usable. Completion raises a sticky interrupt flag.

Several mechanisms guard the array against accidental or interrupted writes. The start bit can be set only by software and cleared only by hardware. An operation starts only directly after a two-step key sequence, and only if the enable bit is set in the same write. A warm reset that lands during an operation cancels it, leaves the array untouched, sets an error flag and keeps the address so that software can retry.

The controller has two state machines. The operation machine has three states. `ST_IDLE` goes to `ST_PROG` on an accepted start. `ST_PROG` goes to `ST_COMMIT` when the busy timer expires. `ST_COMMIT` returns to `ST_IDLE` after one cycle, and that is the cycle in which the array changes. A warm reset forces `ST_IDLE` from any state. The key machine also has three states. `KEY_LOCKED` goes to `KEY_HALF` on a key write of 0x0055. `KEY_HALF` goes to `KEY_OPEN` if the next access is a key write of 0x00AA; any other access sends it back to `KEY_LOCKED`. `KEY_OPEN` returns to `KEY_LOCKED` on the next access of any kind.

Top module: `nvm_word_ctrl`

## Requirements
- R1: After power-on reset, the control register and both address registers read 0x0000, `busy` and `done_irq` are 0, and every array word reads 0xFFFF.
- R2: The byte address is {high[7:0], low[15:0]}. It is valid when it is even and lies in BASE_ADDR .. BASE_ADDR+2*ARRAY_WORDS-1, and it selects word (address-BASE_ADDR)/2. The data register (`reg_sel`=3) reads the selected word, or 0x0000 for an invalid address. A start request with an invalid address is ignored.
- R3: Control bit 3 (start) reads 1 for the whole operation. Writing 0 to it has no effect, and hardware clears it when the operation completes.
- R4: A start request is a control write (`reg_sel`=0) with bit 3 set. It takes effect only if the two accesses just before it were key writes (`reg_sel`=4) of 0x0055 and then 0x00AA. Any other access in between, or the reverse order, discards the unlock.
- R5: A start request is ignored unless bit 2 (enable) is 1 in the same written value.
- R6: A warm reset during an operation aborts it. The error bit (control bit 4) becomes 1, start and enable become 0, the address registers keep their value and the target words are unchanged. Writing 0 to bit 4 clears the error.
- R7: On completion, control bit 5 and `done_irq` become 1. They stay 1 until software writes 0 to bit 5; writing 1 to bit 5 has no effect.
- R8: `busy` is 1 for exactly BUSY_CYCLES+1 clock cycles, starting the cycle after the accepted start write.
- R9: A read of the data register while `busy` is 1 returns 0xDEAD.
- R10: Operation field bits [1:0]: 00 erases the addressed word to 0xFFFF, and 01 erases the aligned 16-word group that contains the addressed word. No other word changes.
- R11: Operation 10 stores old AND latch-entry into the addressed word, so bits can only go from 1 to 0. Operation 11 does the same for all 16 words of the aligned group, using latch entries 0..15 in order.
- R12: A data-register write while idle stores the value in latch entry (word index mod 16). While busy, writes to the data, low address and high address registers are ignored.
- R13: A start request made while busy is ignored, even after a full key sequence, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything |
| warm_rst | input | 1 | Synchronous warm reset (external or watchdog); aborts an operation |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access for the key sequence) |
| reg_sel | input | 3 | Register select: 0 control, 1 address low, 2 address high, 3 data, 4 key |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| busy | output | 1 | An erase or program operation is in progress |
| done_irq | output | 1 | Sticky completion interrupt |

## Verification
A timer that is off by one cycle shows up at once as a `busy` pulse of the wrong length. The bench measures that length for every operation. If the commit step picks the wrong word, the wrong group, or merges the data the wrong way, the next full read-back sweep shows it, and that sweep follows every operation in the sweeps. A key or enable gate that leaks raises `busy` in the very next cycle. Address or latch state that changes during an operation appears in the read-back of the address register, or in the word written by the following operation.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [1:0] {
        OP_ERASE_WORD  = 2'b00,
        OP_ERASE_BLOCK = 2'b01,
        OP_WRITE_WORD  = 2'b10,
        OP_WRITE_BLOCK = 2'b11
    } nvm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROG   = 2'd1,
        ST_COMMIT = 2'd2
    } ctl_state_e;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    localparam logic [2:0] SEL_CTRL    = 3'd0;
    localparam logic [2:0] SEL_ADDR_LO = 3'd1;
    localparam logic [2:0] SEL_ADDR_HI = 3'd2;
    localparam logic [2:0] SEL_DATA    = 3'd3;
    localparam logic [2:0] SEL_KEY     = 3'd4;

    localparam int CB_ENABLE = 2;
    localparam int CB_START  = 3;
    localparam int CB_ERROR  = 4;
    localparam int CB_DONE   = 5;

    localparam logic [15:0] KEY_FIRST  = 16'h0055;
    localparam logic [15:0] KEY_SECOND = 16'h00AA;
    localparam logic [15:0] BUSY_READ  = 16'hDEAD;
    localparam logic [15:0] ERASED     = 16'hFFFF;

endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
    import nvm_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  logic        warm_rst,
    input  logic        any_acc,
    input  logic        key_wr,
    input  logic [15:0] wdata,
    output logic        key_open
);

    key_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_LOCKED: if (key_wr && wdata == KEY_FIRST) state_d = KEY_HALF;
            KEY_HALF:   if (any_acc) state_d = (key_wr && wdata == KEY_SECOND) ? KEY_OPEN : KEY_LOCKED;
            KEY_OPEN:   if (any_acc) state_d = KEY_LOCKED;
            default:    state_d = KEY_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        state_q <= KEY_LOCKED;
        else if (warm_rst) state_q <= KEY_LOCKED;
        else               state_q <= state_d;
    end

    assign key_open = (state_q == KEY_OPEN);

    // R4: the open state is only ever entered from the half-unlocked state
    p_key_order_r4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(state_q == KEY_OPEN) |-> $past(state_q) == KEY_HALF);

endmodule

// File: rtl/nvm_timer.sv
module nvm_timer #(
    parameter int CYCLES = 40000
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear,
    input  logic load,
    output logic expired
);

    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)             cnt_q <= '0;
        else if (clear)         cnt_q <= '0;
        else if (load)          cnt_q <= CW'(CYCLES - 1);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R8: the countdown never holds more than the programmed length
    p_timer_bound_r8: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= CW'(CYCLES - 1));

endmodule

// File: rtl/nvm_array.sv
module nvm_array
    import nvm_pkg::*;
#(
    parameter int WORDS = 64,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          commit,
    input  nvm_op_e       op,
    input  logic [IW-1:0] tgt_idx,
    input  logic          latch_we,
    input  logic [3:0]    latch_sel,
    input  logic [15:0]   latch_din,
    output logic [15:0]   rd_word
);

    localparam int GROUP = 16;

    logic [15:0] latch_q [GROUP];
    logic [15:0] word_w  [WORDS];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int k = 0; k < GROUP; k++) latch_q[k] <= ERASED;
        end else if (latch_we) begin
            latch_q[latch_sel] <= latch_din;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [15:0] cell_q;
        logic        hit;

        assign hit = op[0] ? ((tgt_idx >> 4) == IW'(g / GROUP))
                           : (tgt_idx == IW'(g));

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)              cell_q <= ERASED;
            else if (commit && hit)  cell_q <= op[1] ? (cell_q & latch_q[g % GROUP]) : ERASED;
        end

        assign word_w[g] = cell_q;
    end

    assign rd_word = word_w[tgt_idx];

    // R10: a word erase leaves the addressed word at all ones
    p_erase_word_ones_r10: assert property (@(posedge clk) disable iff (!por_n)
        (commit && op == OP_ERASE_WORD) |=> rd_word == ERASED);

endmodule

// File: rtl/nvm_word_ctrl.sv
module nvm_word_ctrl
    import nvm_pkg::*;
#(
    parameter int          ARRAY_WORDS = 64,
    parameter int          BUSY_CYCLES = 40000,
    parameter logic [23:0] BASE_ADDR   = 24'h7FF000
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        warm_rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        busy,
    output logic        done_irq
);

    localparam int          IW        = $clog2(ARRAY_WORDS);
    localparam logic [23:0] ADDR_LIMIT = 24'(BASE_ADDR + 24'(2 * ARRAY_WORDS));

    ctl_state_e  state_q, state_d;
    nvm_op_e     op_q;
    logic        wren_q, wr_q, err_q, done_q;
    logic [15:0] addr_lo_q;
    logic [7:0]  addr_hi_q;

    logic          ctrl_wr, data_wr, key_wr, any_acc, idle;
    logic          key_open, tmr_done, start_ok, commit;
    logic [23:0]   addr_full, offset;
    logic          addr_ok;
    logic [IW-1:0] word_idx;
    logic [15:0]   rd_word;

    assign any_acc   = reg_wr || reg_rd;
    assign ctrl_wr   = reg_wr && reg_sel == SEL_CTRL;
    assign data_wr   = reg_wr && reg_sel == SEL_DATA;
    assign key_wr    = reg_wr && reg_sel == SEL_KEY;
    assign idle      = (state_q == ST_IDLE);
    assign addr_full = {addr_hi_q, addr_lo_q};
    assign offset    = addr_full - BASE_ADDR;
    assign addr_ok   = !addr_full[0] && addr_full >= BASE_ADDR && addr_full < ADDR_LIMIT;
    assign word_idx  = IW'(offset >> 1);
    assign start_ok  = ctrl_wr && reg_wdata[CB_START] && reg_wdata[CB_ENABLE]
                       && key_open && idle && addr_ok;
    assign commit    = (state_q == ST_COMMIT) && !warm_rst;

    nvm_unlock u_unlock (
        .clk      (clk),
        .por_n    (por_n),
        .warm_rst (warm_rst),
        .any_acc  (any_acc),
        .key_wr   (key_wr),
        .wdata    (reg_wdata),
        .key_open (key_open)
    );

    nvm_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .por_n   (por_n),
        .clear   (warm_rst),
        .load    (start_ok),
        .expired (tmr_done)
    );

    nvm_array #(.WORDS(ARRAY_WORDS)) u_array (
        .clk       (clk),
        .por_n     (por_n),
        .commit    (commit),
        .op        (op_q),
        .tgt_idx   (word_idx),
        .latch_we  (data_wr && idle),
        .latch_sel (4'(offset >> 1)),
        .latch_din (reg_wdata),
        .rd_word   (rd_word)
    );

    // operation state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_PROG;
            ST_PROG:   if (tmr_done) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operation state machine: state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        state_q <= ST_IDLE;
        else if (warm_rst) state_q <= ST_IDLE;
        else               state_q <= state_d;
    end

    // control bits
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            op_q   <= OP_ERASE_WORD;
            wren_q <= 1'b0;
            wr_q   <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else if (warm_rst) begin
            wr_q   <= 1'b0;
            wren_q <= 1'b0;
            if (!idle) err_q <= 1'b1;
        end else begin
            if (ctrl_wr) begin
                wren_q <= reg_wdata[CB_ENABLE];
                err_q  <= err_q & reg_wdata[CB_ERROR];
                if (idle) op_q <= nvm_op_e'(reg_wdata[1:0]);
            end
            if (start_ok)                    wr_q <= 1'b1;
            else if (state_q == ST_COMMIT)   wr_q <= 1'b0;
            done_q <= (ctrl_wr ? (done_q & reg_wdata[CB_DONE]) : done_q)
                      | (state_q == ST_COMMIT);
        end
    end

    // address registers: frozen while an operation runs, kept on warm reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
        end else if (idle && !warm_rst && reg_wr) begin
            if (reg_sel == SEL_ADDR_LO) addr_lo_q <= reg_wdata;
            if (reg_sel == SEL_ADDR_HI) addr_hi_q <= reg_wdata[7:0];
        end
    end

    // outputs
    always_comb begin
        busy     = !idle;
        done_irq = done_q;
        unique case (reg_sel)
            SEL_CTRL:    reg_rdata = {10'b0, done_q, err_q, wr_q, wren_q, op_q};
            SEL_ADDR_LO: reg_rdata = addr_lo_q;
            SEL_ADDR_HI: reg_rdata = {8'b0, addr_hi_q};
            SEL_DATA:    reg_rdata = !idle ? BUSY_READ : (addr_ok ? rd_word : 16'h0000);
            default:     reg_rdata = 16'h0000;
        endcase
    end

    // R3: start bit drops only at the commit step or on a warm reset
    p_wr_hw_clear_r3: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wr_q) |-> ($past(state_q) == ST_COMMIT || $past(warm_rst)));

    // R3: the start bit stays set for as long as the operation is running
    p_wr_tracks_busy_r3: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_IDLE) |-> wr_q);

    // R4: an operation only begins right after the key sequence opened the lock
    p_start_unlocked_r4: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wr_q) |-> $past(key_open));

    // R5: an operation only begins when the written value carries the enable bit
    p_start_enabled_r5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wr_q) |-> $past(reg_wdata[CB_ENABLE]));

    // R6: a warm reset that cuts an operation short leaves the error flag set
    p_abort_err_r6: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst && state_q != ST_IDLE) |=> err_q);

    // R6: the address survives a warm reset
    p_abort_addr_r6: assert property (@(posedge clk) disable iff (!por_n)
        warm_rst |=> $stable(addr_full));

    // R7: the completion flag stays up until a control write
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
        (done_q && !ctrl_wr) |=> done_q);

    // R12: address cannot move during an operation
    p_busy_addr_hold_r12: assert property (@(posedge clk) disable iff (!por_n)
        (state_q != ST_IDLE) |=> $stable(addr_full));

endmodule

// File: tb/nvm_word_ctrl_tb.sv
module nvm_word_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 32;
    localparam int CYC        = 20;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        busy, done_irq;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] mem_m   [WORDS];
    logic [15:0] latch_m [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nvm_word_ctrl #(
        .ARRAY_WORDS (WORDS),
        .BUSY_CYCLES (CYC),
        .BASE_ADDR   (24'h7FF000)
    ) dut_i (
        .clk       (clk),
        .por_n     (por_n),
        .warm_rst  (warm_rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done_irq  (done_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc_wr(input logic [2:0] sel, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic acc_rd(input logic [2:0] sel, output logic [15:0] q);
        reg_rd = 1'b1; reg_sel = sel;
        #3 q = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic set_addr(input int i);
        acc_wr(3'd2, 16'h007F);
        acc_wr(3'd1, 16'(16'hF000 + 2 * i));
    endtask

    task automatic launch(input logic [1:0] op);
        acc_wr(3'd4, 16'h0055);
        acc_wr(3'd4, 16'h00AA);
        acc_wr(3'd0, 16'h000C | {14'b0, op});
    endtask

    task automatic wait_op(output int c);
        c = 0;
        while (busy && c < 1000) begin
            c++;
            @(posedge clk); #1;
        end
    endtask

    task automatic model_apply(input logic [1:0] op, input int idx);
        int grp;
        grp = (idx / 16) * 16;
        case (op)
            2'b00: mem_m[idx] = 16'hFFFF;
            2'b01: for (int k = 0; k < 16; k++) mem_m[grp + k] = 16'hFFFF;
            2'b10: mem_m[idx] = mem_m[idx] & latch_m[idx % 16];
            default: for (int k = 0; k < 16; k++) mem_m[grp + k] = mem_m[grp + k] & latch_m[k];
        endcase
    endtask

    task automatic do_op(input logic [1:0] op, input int idx);
        int c;
        logic [15:0] q;
        set_addr(idx);
        launch(op);
        wait_op(c);
        chk("R8 busy length", 16'(c), 16'(CYC + 1));
        chk("R7 irq after completion", {15'b0, done_irq}, 16'h0001);
        acc_rd(3'd0, q);
        chk("R3 start bit cleared by hardware", q & 16'h0008, 16'h0000);
        model_apply(op, idx);
        acc_wr(3'd0, 16'h0000);
    endtask

    task automatic load_latch(input int i, input logic [15:0] d);
        set_addr(i);
        acc_wr(3'd3, d);
        latch_m[i % 16] = d;
    endtask

    task automatic check_all(input string tag);
        logic [15:0] q;
        for (int i = 0; i < WORDS; i++) begin
            set_addr(i);
            acc_rd(3'd3, q);
            chk(tag, q, mem_m[i]);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(tag, {15'b0, busy}, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] q;
        int c;
        for (int i = 0; i < WORDS; i++) mem_m[i] = 16'hFFFF;
        for (int k = 0; k < 16; k++) latch_m[k] = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1 por_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        acc_rd(3'd0, q); chk("R1 ctrl reset", q, 16'h0000);
        acc_rd(3'd1, q); chk("R1 addr low reset", q, 16'h0000);
        acc_rd(3'd2, q); chk("R1 addr high reset", q, 16'h0000);
        chk("R1 busy reset", {15'b0, busy}, 16'h0000);
        chk("R1 irq reset", {15'b0, done_irq}, 16'h0000);
        check_all("R1 array erased at reset");

        // R11 word writes over every word (erased cells), R12 latch indexing
        for (int i = 0; i < WORDS; i++) begin
            load_latch(i, 16'(i * 16'h0123) ^ 16'hA5A5);
            do_op(2'b10, i);
        end
        check_all("R11 word write sweep");

        // R11 write without erase merges by AND
        load_latch(3, 16'h0F0F);
        do_op(2'b10, 3);
        check_all("R11 and-merge without erase");

        // R10 word erase
        do_op(2'b00, 3);
        check_all("R10 word erase");

        // R10 block erase from a mid-block address, R11 block write
        for (int i = 16; i < 32; i++) load_latch(i, 16'(i * 16'h0571) ^ 16'h3C3C);
        do_op(2'b01, 20);
        check_all("R10 block erase upper group");
        do_op(2'b11, 27);
        check_all("R11 block write upper group");
        do_op(2'b01, 9);
        check_all("R10 block erase lower group");

        // R4 / R5 unlock gating, target word 2
        load_latch(2, 16'h1234);
        do_op(2'b10, 2);
        set_addr(2);
        acc_wr(3'd0, 16'h000C);
        check_idle("R4 start without key");
        acc_wr(3'd4, 16'h00AA); acc_wr(3'd4, 16'h0055); acc_wr(3'd0, 16'h000C);
        check_idle("R4 keys reversed");
        acc_wr(3'd4, 16'h0055); acc_rd(3'd0, q); acc_wr(3'd4, 16'h00AA); acc_wr(3'd0, 16'h000C);
        check_idle("R4 read between keys");
        acc_wr(3'd4, 16'h0055); acc_wr(3'd4, 16'h00AA); acc_rd(3'd1, q); acc_wr(3'd0, 16'h000C);
        check_idle("R4 read between key and start");
        acc_wr(3'd4, 16'h0055); acc_wr(3'd4, 16'h00AA); acc_wr(3'd0, 16'h0008);
        check_idle("R5 start with enable clear");
        acc_rd(3'd0, q);
        chk("R4 start bit stays clear when gated", q & 16'h0008, 16'h0000);
        acc_wr(3'd0, 16'h0000);
        check_all("R4 array untouched by gated starts");

        // R2 invalid addresses
        acc_wr(3'd2, 16'h007F); acc_wr(3'd1, 16'hF001);
        acc_rd(3'd3, q); chk("R2 odd address reads zero", q, 16'h0000);
        launch(2'b00); check_idle("R2 odd address start ignored");
        acc_wr(3'd1, 16'(16'hF000 + 2 * WORDS));
        acc_rd(3'd3, q); chk("R2 above window reads zero", q, 16'h0000);
        launch(2'b00); check_idle("R2 above window start ignored");
        acc_wr(3'd2, 16'h007E); acc_wr(3'd1, 16'hFFFE);
        acc_rd(3'd3, q); chk("R2 below window reads zero", q, 16'h0000);
        launch(2'b00); check_idle("R2 below window start ignored");
        acc_wr(3'd0, 16'h0000);
        check_all("R2 array untouched");

        // busy-phase behaviour on word 7
        load_latch(7, 16'h00F0);
        set_addr(7);
        launch(2'b10);
        acc_rd(3'd3, q); chk("R9 read while busy", q, 16'hDEAD);
        acc_wr(3'd0, 16'h0000);
        acc_rd(3'd0, q); chk("R3 writing zero keeps start bit", q, 16'h000A);
        acc_wr(3'd1, 16'h0000);
        acc_rd(3'd1, q); chk("R12 address write ignored while busy", q, 16'(16'hF000 + 14));
        acc_wr(3'd3, 16'h0000);
        acc_wr(3'd4, 16'h0055); acc_wr(3'd4, 16'h00AA); acc_wr(3'd0, 16'h000D);
        wait_op(c);
        model_apply(2'b10, 7);
        @(posedge clk); #1;
        check_idle("R13 no second operation after busy start");
        chk("R7 irq after busy-phase op", {15'b0, done_irq}, 16'h0001);
        acc_wr(3'd0, 16'h0000);
        check_all("R13 busy start did not erase group");
        do_op(2'b00, 7);
        do_op(2'b10, 7);
        check_all("R12 latch kept value despite busy write");

        // R6 abort by warm reset
        set_addr(5);
        launch(2'b00);
        repeat (3) @(posedge clk);
        #1 warm_rst = 1'b1;
        @(posedge clk); #1 warm_rst = 1'b0;
        check_idle("R6 abort stops operation");
        acc_rd(3'd0, q); chk("R6 error set, start and enable clear", q, 16'h0010);
        acc_rd(3'd1, q); chk("R6 address low kept", q, 16'(16'hF000 + 10));
        acc_rd(3'd2, q); chk("R6 address high kept", q, 16'h007F);
        acc_rd(3'd3, q); chk("R6 target unchanged", q, mem_m[5]);
        acc_wr(3'd0, 16'h0010);
        acc_rd(3'd0, q); chk("R6 writing one keeps error", q & 16'h0010, 16'h0010);
        acc_wr(3'd0, 16'h0000);
        acc_rd(3'd0, q); chk("R6 error cleared by zero", q, 16'h0000);
        launch(2'b00);
        wait_op(c);
        chk("R6 retry runs full length", 16'(c), 16'(CYC + 1));
        model_apply(2'b00, 5);
        check_all("R6 retry result");

        // R7 sticky interrupt
        repeat (5) @(posedge clk); #1;
        chk("R7 irq held while idle", {15'b0, done_irq}, 16'h0001);
        acc_wr(3'd0, 16'h0020);
        chk("R7 writing one keeps irq", {15'b0, done_irq}, 16'h0001);
        acc_wr(3'd0, 16'h0000);
        chk("R7 writing zero clears irq", {15'b0, done_irq}, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule